// File: doc/BRIEF.md
# String Repeat Loop Sequencer

This block drives the repeated execution of a string primitive under a repeat prefix and a count. A request carries a prefix byte, a class bit that says whether the primitive sets flags (compare or scan) or does not (move, load or store), and a starting count. While the count is not zero, the sequencer gives an external primitive datapath a one-cycle start pulse. It waits for that datapath to report completion with a zero-flag value, and then decrements the count by one.

For flag-setting primitives, each repetition also compares the reported zero flag with bit 0 of the prefix, called the Z bit. A mismatch ends the loop at once, after that repetition's decrement has been made. For the other class the zero flag has no effect. When the loop ends, the block pulses `done` for one cycle and presents the remaining count and a two-bit cause code. The cause code tells whether the count ran out, a flag mismatch ended the loop, or the count was zero from the start.

Top module: `strrep_seq`

## Requirements
- R1: After a synchronous reset, `busy`, `done` and `prim_start` are 0 and `cause` is 2'b00.
- R2: A request is taken only when `req_valid` is 1, the block is idle and `req_prefix[7:1]` equals 7'b1111001. Any other prefix value leaves the block idle.
- R3: If the accepted count is zero, the loop finishes with no `prim_start` pulse, `final_count` is 0 and `cause` is 2'b11.
- R4: Each repetition gives exactly one single-cycle `prim_start`. The block then waits for `prim_done` for as many cycles as the datapath takes, and decrements the count by one.
- R5: When the count is zero at the check that comes before a repetition, and at least one repetition has run, the loop ends with `cause` 2'b01 and `final_count` 0.
- R6: For the flag-setting class (`req_cmp`=1), a `prim_zf` different from `req_prefix[0]` ends the loop after that repetition with `cause` 2'b10. The count has already been decremented. A mismatch on the repetition that brings the count to zero still reports 2'b10.
- R7: For the non-flag class (`req_cmp`=0), `prim_zf` has no effect, and prefix values 8'hF2 and 8'hF3 both repeat until the count runs out.
- R8: `busy` is 1 from the cycle after acceptance through the `done` cycle, and `done` lasts one cycle. A request presented while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_prefix | input | 8 | Repeat prefix byte; bit 0 is the Z bit |
| req_cmp | input | 1 | 1 = flag-setting primitive, 0 = non-flag primitive |
| req_count | input | CW (16) | Starting repeat count |
| prim_start | output | 1 | One-cycle start to the primitive datapath |
| prim_done | input | 1 | Primitive completion strobe |
| prim_zf | input | 1 | Zero flag reported with `prim_done` |
| busy | output | 1 | Loop in progress |
| done | output | 1 | One-cycle loop-finished pulse |
| final_count | output | CW (16) | Remaining count, valid with `done` |
| cause | output | 2 | 01 count exhausted, 10 flag mismatch, 11 zero start count |

## Verification
The loop runs with both prefix values and both primitive classes, against zero-flag patterns that stay matched, that mismatch on the first repetition, and that mismatch only on the last repetition. This separates the exhausted exit from the mismatch exit and checks which one wins when both apply at once. Zero and one starting counts and varied datapath latencies test the check-before-run order and the single start per repetition. Invalid prefixes and requests made in mid-loop show that the block ignores them.

// File: rtl/strrep_pkg.sv
package strrep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_START, ST_WAIT, ST_UPDATE, ST_DONE
  } seq_state_t;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'b00,
    CAUSE_EXHAUST  = 2'b01,
    CAUSE_MISMATCH = 2'b10,
    CAUSE_ZERO     = 2'b11
  } end_cause_t;
endpackage

// File: rtl/strrep_prefix_dec.sv
module strrep_prefix_dec #(
  parameter int PFX_W = 8,
  parameter logic [PFX_W-2:0] TAG = 7'b1111001
) (
  input  logic [PFX_W-1:0] prefix,
  output logic             hit,
  output logic             zbit
);
  localparam int TAG_W = PFX_W - 1;

  always_comb begin
    hit  = (prefix[PFX_W-1 -: TAG_W] == TAG);
    zbit = prefix[0];
  end
endmodule

// File: rtl/strrep_cnt.sv
module strrep_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic [CW-1:0] cnt,
  output logic          is_zero
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - ONE;
  end

  assign is_zero = (cnt == '0);

  AST_DEC_NONZERO: assert property (@(posedge clk) disable iff (rst)
    dec |-> !is_zero); // R4
endmodule

// File: rtl/strrep_ctrl.sv
module strrep_ctrl
  import strrep_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       accept,
  input  logic       zbit_in,
  input  logic       cmp_in,
  input  logic       cnt_zero,
  input  logic       prim_done,
  input  logic       prim_zf,
  output logic       load,
  output logic       dec,
  output logic       prim_start,
  output logic       busy,
  output logic       done,
  output logic [1:0] cause
);
  seq_state_t state;
  end_cause_t cause_q;
  logic       zb_q, cmp_q, zf_q, first_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cause_q <= CAUSE_NONE;
      zb_q    <= 1'b0;
      cmp_q   <= 1'b0;
      zf_q    <= 1'b0;
      first_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state   <= ST_CHECK;
          zb_q    <= zbit_in;
          cmp_q   <= cmp_in;
          first_q <= 1'b1;
          cause_q <= CAUSE_NONE;
        end
        ST_CHECK: if (cnt_zero) begin
          state   <= ST_DONE;
          cause_q <= first_q ? CAUSE_ZERO : CAUSE_EXHAUST;
        end else begin
          state <= ST_START;
        end
        ST_START: begin
          state   <= ST_WAIT;
          first_q <= 1'b0;
        end
        ST_WAIT: if (prim_done) begin
          zf_q  <= prim_zf;
          state <= ST_UPDATE;
        end
        ST_UPDATE: if (cmp_q && (zf_q != zb_q)) begin
          state   <= ST_DONE;
          cause_q <= CAUSE_MISMATCH;
        end else begin
          state <= ST_CHECK;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign load       = (state == ST_IDLE) && accept;
  assign dec        = (state == ST_UPDATE);
  assign prim_start = (state == ST_START);
  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_DONE);
  assign cause      = cause_q;

  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    prim_start |=> !prim_start); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> busy); // R8
  AST_BUSY_FROM_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(accept)); // R2
  AST_ZERO_START: assert property (@(posedge clk) disable iff (rst)
    (done && cause == CAUSE_ZERO) |-> cnt_zero); // R3
  AST_EXHAUST_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done && cause == CAUSE_EXHAUST) |-> cnt_zero); // R5
  AST_MISMATCH_REAL: assert property (@(posedge clk) disable iff (rst)
    (done && cause == CAUSE_MISMATCH) |-> (zf_q != zb_q)); // R6
  AST_MOVE_NO_MISMATCH: assert property (@(posedge clk) disable iff (rst)
    (done && !cmp_q) |-> (cause != CAUSE_MISMATCH)); // R7
endmodule

// File: rtl/strrep_seq.sv
module strrep_seq #(
  parameter int CW    = 16,
  parameter int PFX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [PFX_W-1:0] req_prefix,
  input  logic             req_cmp,
  input  logic [CW-1:0]    req_count,
  output logic             prim_start,
  input  logic             prim_done,
  input  logic             prim_zf,
  output logic             busy,
  output logic             done,
  output logic [CW-1:0]    final_count,
  output logic [1:0]       cause
);
  logic hit, zbit, load, dec, cnt_zero, accept;

  strrep_prefix_dec #(.PFX_W(PFX_W)) u_dec (
    .prefix (req_prefix),
    .hit    (hit),
    .zbit   (zbit)
  );

  assign accept = req_valid && hit;

  strrep_cnt #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (req_count),
    .dec      (dec),
    .cnt      (final_count),
    .is_zero  (cnt_zero)
  );

  strrep_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .zbit_in    (zbit),
    .cmp_in     (req_cmp),
    .cnt_zero   (cnt_zero),
    .prim_done  (prim_done),
    .prim_zf    (prim_zf),
    .load       (load),
    .dec        (dec),
    .prim_start (prim_start),
    .busy       (busy),
    .done       (done),
    .cause      (cause)
  );
endmodule

// File: tb/tb_strrep_seq.sv
module tb_strrep_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [7:0]  req_prefix = 8'h00;
  logic        req_cmp = 1'b0;
  logic [15:0] req_count = 16'h0;
  logic        prim_start, prim_done = 1'b0, prim_zf = 1'b0;
  logic        busy, done;
  logic [15:0] final_count;
  logic [1:0]  cause;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  strrep_seq dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_prefix(req_prefix),
    .req_cmp(req_cmp), .req_count(req_count), .prim_start(prim_start),
    .prim_done(prim_done), .prim_zf(prim_zf), .busy(busy), .done(done),
    .final_count(final_count), .cause(cause)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit b, input bit s, input bit d, input string tag);
    check({tag, " busy"}, busy, b);
    check({tag, " prim_start"}, prim_start, s);
    check({tag, " done"}, done, d);
  endtask

  // Reference model: walks the loop rule by rule and compares every clock.
  task automatic run(input logic [7:0] pfx, input bit cmp, input int cnt,
                     input logic [15:0] zfpat, input int lat, input bit poke,
                     input string tag);
    int c = cnt;
    int it = 0;
    bit first = 1;
    bit zf = 0;
    int exp_cause = 0;
    @(negedge clk);
    req_valid = 1; req_prefix = pfx; req_cmp = cmp; req_count = cnt[15:0];
    @(negedge clk);
    req_valid = 0;
    forever begin
      cyc(1, 0, 0, {tag, " R8 check"});
      if (c == 0) begin exp_cause = first ? 3 : 1; break; end
      @(negedge clk); cyc(1, 1, 0, {tag, " R4 start"});
      first = 0;
      @(negedge clk);
      for (int k = 0; k < lat; k++) begin
        cyc(1, 0, 0, {tag, " R4 wait"});
        if (poke && k == 0) begin
          req_valid = 1; req_prefix = 8'hF2; req_cmp = ~cmp; req_count = 16'd7;
        end
        @(negedge clk);
      end
      cyc(1, 0, 0, {tag, " R4 wait"});
      req_valid = 0;
      zf = zfpat[it[3:0]];
      prim_done = 1; prim_zf = zf;
      @(negedge clk);
      prim_done = 0; prim_zf = 0;
      cyc(1, 0, 0, {tag, " R4 update"});
      c--; it++;
      if (cmp && zf != pfx[0]) begin exp_cause = 2; break; end
      @(negedge clk);
    end
    @(negedge clk);
    cyc(1, 0, 1, {tag, " R8 done"});
    check({tag, " final_count"}, final_count, c);
    check({tag, " cause"}, cause, exp_cause);
    if (poke) begin
      req_valid = 1; req_prefix = 8'hF3; req_cmp = 1; req_count = 16'd9;
    end
    @(negedge clk);
    req_valid = 0;
    cyc(0, 0, 0, {tag, " R8 idle"});
    @(negedge clk);
    cyc(0, 0, 0, {tag, " R8 ignored"});
  endtask

  task automatic bad_prefix(input logic [7:0] pfx);
    @(negedge clk);
    req_valid = 1; req_prefix = pfx; req_cmp = 1; req_count = 16'd4;
    @(negedge clk);
    req_valid = 0;
    cyc(0, 0, 0, "R2 bad prefix");
    @(negedge clk);
    cyc(0, 0, 0, "R2 bad prefix");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cyc(0, 0, 0, "R1 reset");
    check("R1 reset cause", cause, 0);

    bad_prefix(8'h90);
    bad_prefix(8'hF4);
    bad_prefix(8'hF1);
    bad_prefix(8'h72);

    run(8'hF3, 0, 0, 16'h0000, 1, 0, "R3 zero move");
    run(8'hF2, 1, 0, 16'hFFFF, 1, 0, "R3 zero cmp");
    run(8'hF3, 0, 5, 16'h0000, 1, 0, "R7 R5 move F3");
    run(8'hF2, 0, 3, 16'hFFFF, 2, 0, "R7 R5 move F2");
    run(8'hF3, 1, 6, 16'h0003, 1, 0, "R6 mismatch third");
    run(8'hF2, 1, 4, 16'h0000, 0, 0, "R5 cmp exhausted");
    run(8'hF2, 1, 10, 16'h0001, 3, 0, "R6 mismatch first");
    run(8'hF3, 1, 2, 16'h0001, 1, 0, "R6 mismatch on last");
    run(8'hF3, 1, 3, 16'hFFFF, 2, 1, "R8 poke busy");
    run(8'hF3, 0, 1, 16'h0000, 3, 0, "R4 single");
    run(8'hF2, 1, 18, 16'h0000, 0, 0, "R4 R5 long");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule